// File: doc/BRIEF.md
# Eight-Point Fast Discrete Cosine Transform

This block computes a one-dimensional, eight-point DCT-II on a vector of eight signed samples presented side by side on one wide input bus. It uses a staged butterfly decomposition rather than a full eight-by-eight matrix product. Sum and difference butterflies split the vector into an even half and an odd half. The even half is finished with a small set of cosine multiplies. The odd half goes through a four-by-four multiply-accumulate matrix of cosine constants. A final stage rounds every result and puts the eight coefficients back in natural index order.

The pipeline accepts a new vector on every clock and returns each result a fixed number of cycles later, with a valid strobe travelling alongside the data. A two-dimensional transform is built by feeding rows and then columns through it. The transpose storage that this needs sits outside the block.

Top module: `dct8_fast`

## Requirements
- R1: Input sample n (n = 0..7) is a 12-bit two's-complement value on `in_x[12n+11:12n]`. Coefficient k (k = 0..7) is a 16-bit two's-complement value on `out_y[16k+15:16k]`, in natural index order.
- R2: Each coefficient y_k equals one half of the sum over n of x_n·cos((2n+1)·k·π/16). y_0 carries an extra factor of 1/√2. Every coefficient is within ±2 LSB of this real-valued result.
- R3: `out_valid` rises exactly four rising clock edges after the edge that samples `in_valid` high. The data present with it belongs to that input vector.
- R4: A vector is accepted on every cycle that has `in_valid` high, including back-to-back cycles. Idle cycles in the input appear as idle cycles in `out_valid`, and the number of results equals the number of vectors accepted.
- R5: `rst_n` is synchronous and active low. An edge that samples it low clears every pipeline valid stage, so `out_valid` is low in the following cycle. Vectors that were in flight are never presented.
- R6: The cosine constants are Q1.13 values rounded to nearest; for example the constant for π/4 is 5793. Results are rounded half away from zero. All samples at 1024 give y_0 = 2897, and all samples at -1024 give y_0 = -2897.
- R7: An input that is mirror-symmetric (x_n = x_{7-n}) gives exactly zero on y_1, y_3, y_5 and y_7. A mirror-antisymmetric input (x_n = -x_{7-n}) gives exactly zero on y_0, y_2, y_4 and y_6.
- R8: No result wraps around at full scale. All samples at -2048 give y_0 = -5793 and exactly zero on every other coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Qualifies the vector on `in_x` this cycle |
| in_x | input | 96 | Eight 12-bit signed samples, sample 0 in the low bits |
| out_valid | output | 1 | Qualifies the coefficients on `out_y` |
| out_y | output | 128 | Eight 16-bit signed coefficients, coefficient 0 in the low bits |

## Verification
Every coefficient of a vector is due on the fourth rising edge after the edge that samples that vector. The bench records the cycle count each time it drives a vector and compares it with the cycle count at which the matching `out_valid` is seen at the following falling edge. The difference must be exactly four, and results are paired with vectors strictly in send order. Gapped traffic and a reset asserted while vectors are in flight check that no result arrives early, late, twice or at all when it should have been dropped.

// File: rtl/dct8_pkg.sv
// Package: shared constants for the eight-point DCT datapath.
// Holds the Q1.13 cosine constants and two lookup functions. The first gives
// the sign pattern of the odd-half matrix; the second maps the datapath's
// internal result order back to natural coefficient order.
// Assumes a 14-bit signed constant format with 13 fraction bits.
package dct8_pkg;

    localparam int COEF_W    = 14;
    localparam int COEF_FRAC = 13;
    localparam int NPT       = 8;
    localparam int HALF_N    = NPT / 2;

    typedef logic signed [COEF_W-1:0] coef_t;

    // cos(k*pi/16) scaled by 2^13 and rounded to nearest
    localparam coef_t K1 = 14'sd8035;
    localparam coef_t K2 = 14'sd7568;
    localparam coef_t K3 = 14'sd6811;
    localparam coef_t K4 = 14'sd5793;
    localparam coef_t K5 = 14'sd4551;
    localparam coef_t K6 = 14'sd3135;
    localparam coef_t K7 = 14'sd1598;

    // Odd-half matrix: row r yields coefficient 2r+1; column c weights difference c
    function automatic coef_t odd_coef(input int row, input int col);
        case (row * 4 + col)
            0:  return K1;
            1:  return K3;
            2:  return K5;
            3:  return K7;
            4:  return K3;
            5:  return -K7;
            6:  return -K1;
            7:  return -K5;
            8:  return K5;
            9:  return -K1;
            10: return K7;
            11: return K3;
            12: return K7;
            13: return -K5;
            14: return K3;
            default: return -K1;
        endcase
    endfunction

    // Internal slot order is {y0, y4, y2, y6, y1, y3, y5, y7}
    function automatic int nat_index(input int slot);
        case (slot)
            0: return 0;
            1: return 4;
            2: return 2;
            3: return 6;
            4: return 1;
            5: return 3;
            6: return 5;
            default: return 7;
        endcase
    endfunction

endpackage

// File: rtl/dct8_butterfly.sv
// Module: the first two pipeline stages of the transform.
// Stage one forms the mirrored sums s_i = x_i + x_(7-i) and the differences
// d_i = x_i - x_(7-i). Stage two folds the sums once more into
// {s0+s3, s1+s2, s0-s3, s1-s2} and delays the differences by one cycle so
// that both halves stay aligned.
// Assumes full word growth: one extra bit per butterfly level, with no
// saturation. The data registers are free-running and are not reset.
module dct8_butterfly #(
    parameter int IN_W = 12
) (
    input  logic                                  clk,
    input  logic [dct8_pkg::NPT*IN_W-1:0]         x_i,
    output logic signed [IN_W+1:0]                even_o [dct8_pkg::HALF_N],
    output logic signed [IN_W:0]                  diff_o [dct8_pkg::HALF_N]
);
    localparam int NPT = dct8_pkg::NPT;
    localparam int HN  = dct8_pkg::HALF_N;
    localparam int S1W = IN_W + 1;
    localparam int S2W = IN_W + 2;

    logic signed [IN_W-1:0] lane  [NPT];
    logic signed [S1W-1:0]  sum_q [HN];
    logic signed [S1W-1:0]  dif_q [HN];

    for (genvar n = 0; n < NPT; n++) begin : g_lane
        assign lane[n] = x_i[n*IN_W +: IN_W];
    end

    for (genvar i = 0; i < HN; i++) begin : g_st1
        // Stage 1: mirrored sum and difference of one lane pair
        always_ff @(posedge clk) begin
            sum_q[i] <= S1W'(lane[i]) + S1W'(lane[NPT-1-i]);
            dif_q[i] <= S1W'(lane[i]) - S1W'(lane[NPT-1-i]);
        end
        // Stage 2: carry the differences forward to stay aligned with the even fold
        always_ff @(posedge clk) begin
            diff_o[i] <= dif_q[i];
        end
    end

    // Stage 2: second butterfly level on the even half
    always_ff @(posedge clk) begin
        even_o[0] <= S2W'(sum_q[0]) + S2W'(sum_q[3]);
        even_o[1] <= S2W'(sum_q[1]) + S2W'(sum_q[2]);
        even_o[2] <= S2W'(sum_q[0]) - S2W'(sum_q[3]);
        even_o[3] <= S2W'(sum_q[1]) - S2W'(sum_q[2]);
    end

endmodule

// File: rtl/dct8_even.sv
// Module: pipeline stage three for the even-indexed coefficients.
// Input slots are {e0, e1, f0, f1} from the butterfly. Output slots are the
// unscaled accumulators for {y0, y4, y2, y6}:
// y0 ~ K4*(e0+e1), y4 ~ K4*(e0-e1), y2 ~ K2*f0 + K6*f1, y6 ~ K6*f0 - K2*f1.
// Assumes ACC_W is wide enough to hold the full product growth.
module dct8_even #(
    parameter int IN_W  = 12,
    parameter int ACC_W = 31
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [IN_W+1:0]   even_i [dct8_pkg::HALF_N],
    output logic signed [ACC_W-1:0]  acc_o  [dct8_pkg::HALF_N]
);
    import dct8_pkg::*;
    typedef logic signed [ACC_W-1:0] acc_t;

    acc_t e0, e1, f0, f1;
    assign e0 = acc_t'(even_i[0]);
    assign e1 = acc_t'(even_i[1]);
    assign f0 = acc_t'(even_i[2]);
    assign f1 = acc_t'(even_i[3]);

    // Stage 3: even-half constant multiplies and pair sums
    always_ff @(posedge clk) begin
        acc_o[0] <= acc_t'(K4) * (e0 + e1);
        acc_o[1] <= acc_t'(K4) * (e0 - e1);
        acc_o[2] <= acc_t'(K2) * f0 + acc_t'(K6) * f1;
        acc_o[3] <= acc_t'(K6) * f0 - acc_t'(K2) * f1;
    end

    // An all-zero even half (antisymmetric input) must produce zero even accumulators
    p_even_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (even_i[0] == '0 && even_i[1] == '0 && even_i[2] == '0 && even_i[3] == '0)
        |=> (acc_o[0] == '0 && acc_o[1] == '0 && acc_o[2] == '0 && acc_o[3] == '0));

endmodule

// File: rtl/dct8_odd.sv
// Module: pipeline stage three for the odd-indexed coefficients.
// Each of the four rows multiplies the four difference terms by a signed
// cosine row from the package and sums the products. Output slots are the
// unscaled accumulators for {y1, y3, y5, y7}.
// Assumes ACC_W is wide enough to hold four full-width products.
module dct8_odd #(
    parameter int IN_W  = 12,
    parameter int ACC_W = 31
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [IN_W:0]     diff_i [dct8_pkg::HALF_N],
    output logic signed [ACC_W-1:0]  acc_o  [dct8_pkg::HALF_N]
);
    localparam int HN = dct8_pkg::HALF_N;
    typedef logic signed [ACC_W-1:0] acc_t;

    for (genvar r = 0; r < HN; r++) begin : g_row
        acc_t row_sum;
        // Multiply-accumulate of one matrix row against the differences
        always_comb begin
            row_sum = '0;
            for (int c = 0; c < HN; c++) begin
                row_sum = row_sum + acc_t'(dct8_pkg::odd_coef(r, c)) * acc_t'(diff_i[c]);
            end
        end
        // Stage 3: register the row result
        always_ff @(posedge clk) begin
            acc_o[r] <= row_sum;
        end
    end

    // Zero differences (symmetric input) must give zero odd accumulators
    p_odd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (diff_i[0] == '0 && diff_i[1] == '0 && diff_i[2] == '0 && diff_i[3] == '0)
        |=> (acc_o[0] == '0 && acc_o[1] == '0 && acc_o[2] == '0 && acc_o[3] == '0));

endmodule

// File: rtl/dct8_round.sv
// Module: pipeline stage four. It scales every accumulator down by
// 2^SHIFT with rounding half away from zero, then writes the result into its
// natural output lane.
// Assumes that accumulators come from bounded inputs, so every rounded value
// fits in OUT_W bits; an assertion guards this whenever the stage-3 data is
// valid.
module dct8_round #(
    parameter int ACC_W = 31,
    parameter int OUT_W = 16,
    parameter int SHIFT = 14
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               acc_vld_i,
    input  logic signed [ACC_W-1:0]            acc_i [dct8_pkg::NPT],
    output logic [dct8_pkg::NPT*OUT_W-1:0]     y_o
);
    localparam int NPT = dct8_pkg::NPT;
    typedef logic signed [ACC_W-1:0] acc_t;
    localparam acc_t HALF_C = acc_t'(1) <<< (SHIFT - 1);
    localparam acc_t MAX_C  = acc_t'((64'sd1 <<< (OUT_W - 1)) - 1);
    localparam acc_t MIN_C  = -acc_t'(64'sd1 <<< (OUT_W - 1));

    for (genvar s = 0; s < NPT; s++) begin : g_slot
        localparam int LANE = dct8_pkg::nat_index(s);
        acc_t wide;
        // Round half away from zero: negative values take one less before the floor shift
        always_comb begin
            wide = (acc_i[s] + HALF_C - acc_t'(acc_i[s][ACC_W-1])) >>> SHIFT;
        end
        // Stage 4: store the rounded result in its natural lane
        always_ff @(posedge clk) begin
            y_o[LANE*OUT_W +: OUT_W] <= wide[OUT_W-1:0];
        end

        p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            acc_vld_i |-> (wide <= MAX_C && wide >= MIN_C));
    end

endmodule

// File: rtl/dct8_fast.sv
// Module: top level of the pipelined eight-point fast DCT.
// Joins the butterfly, even, odd and rounding stages, and carries the valid
// strobe through a shift register whose length matches the datapath depth.
// Assumes one vector per clock with no back-pressure. Only the valid bits are
// reset; the data registers run freely.
module dct8_fast #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [dct8_pkg::NPT*IN_W-1:0]   in_x,
    output logic                            out_valid,
    output logic [dct8_pkg::NPT*OUT_W-1:0]  out_y
);
    import dct8_pkg::*;
    localparam int ACC_W = IN_W + COEF_W + 5;
    localparam int SHIFT = COEF_FRAC + 1;
    localparam int LAT   = 4;
    localparam int CNT_W = $clog2(LAT + 1);

    logic [LAT-1:0]           vld;
    logic signed [IN_W+1:0]   even_s [HALF_N];
    logic signed [IN_W:0]     diff_s [HALF_N];
    logic signed [ACC_W-1:0]  even_acc [HALF_N];
    logic signed [ACC_W-1:0]  odd_acc  [HALF_N];
    logic signed [ACC_W-1:0]  all_acc  [NPT];

    // Valid shift register, one bit per datapath stage
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= '0;
        else        vld <= {vld[LAT-2:0], in_valid};
    end
    assign out_valid = vld[LAT-1];

    dct8_butterfly #(.IN_W(IN_W)) u_bfly (
        .clk    (clk),
        .x_i    (in_x),
        .even_o (even_s),
        .diff_o (diff_s)
    );

    dct8_even #(.IN_W(IN_W), .ACC_W(ACC_W)) u_even (
        .clk    (clk),
        .rst_n  (rst_n),
        .even_i (even_s),
        .acc_o  (even_acc)
    );

    dct8_odd #(.IN_W(IN_W), .ACC_W(ACC_W)) u_odd (
        .clk    (clk),
        .rst_n  (rst_n),
        .diff_i (diff_s),
        .acc_o  (odd_acc)
    );

    for (genvar i = 0; i < HALF_N; i++) begin : g_join
        assign all_acc[i]          = even_acc[i];
        assign all_acc[i + HALF_N] = odd_acc[i];
    end

    dct8_round #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_round (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_vld_i (vld[LAT-2]),
        .acc_i     (all_acc),
        .y_o       (out_y)
    );

    // Edges since reset, saturating at LAT, so the latency check never reaches before reset
    logic [CNT_W-1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)                       since_rst <= '0;
        else if (since_rst != CNT_W'(LAT)) since_rst <= since_rst + 1'b1;
    end

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == CNT_W'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

    p_reset_clears_r5: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

// File: tb/dct8_fast_tb.sv
`timescale 1ns/1ps
// Bench for dct8_fast. A table of stimulus vectors is streamed by one loop and
// checked against a real-valued DCT. Directed phases then cover gaps, reset
// in flight and the exact rounding and full-scale corners.
module dct8_fast_tb;
    localparam int IN_W  = 12;
    localparam int OUT_W = 16;
    localparam int NPT   = 8;
    localparam int NVEC  = 11;
    localparam real PI   = 3.14159265358979;

    // Samples x0..x7 per row
    localparam int STIM [0:NVEC-1][0:NPT-1] = '{
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{1000, 0, 0, 0, 0, 0, 0, 0},
        '{0, 100, 200, 300, 400, 500, 600, 700},
        '{2047, -2048, 2047, -2048, 2047, -2048, 2047, -2048},
        '{300, -500, 700, 100, 100, 700, -500, 300},
        '{400, -300, 200, -100, 100, -200, 300, -400},
        '{1024, 1024, 1024, 1024, 1024, 1024, 1024, 1024},
        '{-1024, -1024, -1024, -1024, -1024, -1024, -1024, -1024},
        '{-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048},
        '{123, -456, 789, -1011, 1500, -1999, 37, 888},
        '{2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [NPT*IN_W-1:0]  in_x = '0;
    logic                 out_valid;
    logic [NPT*OUT_W-1:0] out_y;

    dct8_fast #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_x      (in_x),
        .out_valid (out_valid),
        .out_y     (out_y)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_err = 0;
    int q_idx [0:63];
    int q_cyc [0:63];
    int wr = 0;
    int rd = 0;
    int rx = 0;

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_near(input string req, input string what, input int act, input real exp);
        real diff;
        n_chk++;
        diff = $itor(act) - exp;
        if (diff > 2.0 || diff < -2.0) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%f", req, what, act, exp);
        end
    endtask

    function automatic real ref_y(input int k, input int idx);
        real acc = 0.0;
        for (int n = 0; n < NPT; n++)
            acc += $itor(STIM[idx][n]) * $cos(real'((2 * n + 1) * k) * PI / 16.0);
        acc = acc * 0.5;
        if (k == 0) acc = acc / $sqrt(2.0);
        return acc;
    endfunction

    task automatic send(input int idx);
        @(posedge clk);
        #1;
        for (int n = 0; n < NPT; n++) in_x[n*IN_W +: IN_W] = IN_W'(STIM[idx][n]);
        in_valid = 1'b1;
        q_idx[wr] = idx;
        q_cyc[wr] = cyc;
        wr++;
    endtask

    task automatic idle(input int cycles);
        repeat (cycles) begin
            @(posedge clk);
            #1;
            in_valid = 1'b0;
        end
    endtask

    // Output checker, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rd == wr) begin
                chk_int("R4", "unexpected out_valid", 1, 0);
            end else begin
                int idx;
                int y [NPT];
                idx = q_idx[rd];
                chk_int("R3", $sformatf("latency vec%0d", idx), cyc - q_cyc[rd], 4);
                for (int k = 0; k < NPT; k++) begin
                    y[k] = int'($signed(out_y[k*OUT_W +: OUT_W]));
                    chk_near("R2", $sformatf("vec%0d y%0d", idx, k), y[k], ref_y(k, idx));
                end
                if (idx == 0 || idx == 1)
                    chk_int("R1", $sformatf("vec%0d lane y4", idx), y[4], idx == 0 ? 0 : 354);
                if (idx == 4)
                    for (int k = 1; k < NPT; k += 2) chk_int("R7", $sformatf("symmetric y%0d", k), y[k], 0);
                if (idx == 5)
                    for (int k = 0; k < NPT; k += 2) chk_int("R7", $sformatf("antisymmetric y%0d", k), y[k], 0);
                if (idx == 6) chk_int("R6", "half up y0", y[0], 2897);
                if (idx == 7) chk_int("R6", "half down y0", y[0], -2897);
                if (idx == 8) begin
                    chk_int("R8", "full scale y0", y[0], -5793);
                    for (int k = 1; k < NPT; k++) chk_int("R8", $sformatf("full scale y%0d", k), y[k], 0);
                end
                rd++;
                rx++;
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_int("R5", "out_valid during reset", int'(out_valid), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // Table walk, back to back (R4)
        for (int i = 0; i < NVEC; i++) send(i);
        idle(1);
        repeat (8) @(posedge clk);

        // Gapped traffic (R4, R3)
        send(2);
        idle(2);
        send(9);
        idle(1);
        send(3);
        idle(1);
        repeat (8) @(posedge clk);

        // Reset while two vectors are in flight (R5)
        send(9);
        send(2);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        rd = wr;
        repeat (6) begin
            @(negedge clk);
            chk_int("R5", "flushed out_valid", int'(out_valid), 0);
        end

        // Recovery after reset
        send(5);
        idle(1);
        repeat (8) @(posedge clk);

        chk_int("R4", "results returned", rx, NVEC + 4);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule